// File: doc/BRIEF.md
# Multiplexed DAC Refresh Sequencer

This block keeps a bank of analog hold channels charged from a single shared DAC. The bank holds one 12-bit setting per channel in an external byte-wide RAM, two bytes per channel. Without pause the block walks the channels in order. For each channel it reads the high byte and then the low byte, and loads each into the DAC register with its own strobe. It then lets the DAC output settle and opens the analog demultiplexer gate for that channel for a fixed time. The demultiplexer is held inhibited whenever its address moves, so the address always changes with the gate closed before it reopens.

A command parser elsewhere writes new bytes into the same RAM through a request input. A write takes priority over the scan. It is accepted at the next point where the gate is closed and occupies the RAM for one cycle. A fixed dead time follows, and then the scan resumes. If the write cut into a channel's slot, that channel is refreshed again from its first read. There is no direct conversion path, so a new value reaches its channel at that channel's next gate. All timing is counted in clock cycles and set by parameters. With the defaults at 50 MHz, a full scan of 32 channels takes well under one 320 µs serial byte time.

Top module: `dacRefreshSeq`

## Requirements
- R1: While and right after reset: `muxInhibit` is 1, `dacHiStb`, `dacLoStb`, `ramWe`, `wrAck` and `scanWrap` are 0, `dacValue` is 0, and the first channel refreshed is channel 0.
- R2: For channel c, the RAM is read at byte address 2c (high half) for READ_CYC cycles, with `dacHiStb` in the last of them. It is then read at address 2c+1 (low half) for READ_CYC cycles, with `dacLoStb` in the last.
- R3: `dacValue` is {high byte bits 6..0, low byte bits 4..0}. High-byte bit 7 and low-byte bits 7..5 have no effect on it.
- R4: The gate opens (`muxInhibit` falls) exactly SETTLE_CYC+1 cycles after the cycle that carries `dacLoStb`.
- R5: The gate stays open for exactly GATE_CYC cycles. While it is open, `muxAddr` and `dacValue` do not change. `muxAddr` changes only in a cycle where `muxInhibit` is 1 in that cycle and in the one before.
- R6: Channels are gated in order 0,1,…,NUM_CH-1 and then back to 0. `scanWrap` pulses for one cycle each time the scan leaves channel NUM_CH-1.
- R7: With no writes, consecutive gate openings are exactly 2·READ_CYC+SETTLE_CYC+GATE_CYC+GUARD_CYC cycles apart.
- R8: A held `wrReq` is served within GATE_CYC+2 cycles. The service is a single cycle with `ramWe`=`wrAck`=1, `ramAddr`=`wrAddr` and `ramWrData`=`wrData`, and it never happens while the gate is open or in the cycle just after it closes.
- R9: After a write cycle the block idles DEAD_CYC cycles and ignores `wrReq` during them. The next high strobe, if no further write intervenes, comes exactly DEAD_CYC+READ_CYC cycles after the write cycle.
- R10: A write that interrupts a channel before its gate makes that channel restart at its high-byte read. No channel is skipped and none is gated without both reads.
- R11: A value written into RAM appears on `dacValue` at the next gate of that channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrReq | input | 1 | Write request, held until `wrAck` |
| wrAddr | input | CH_W+1 | Byte address of the write (2c high, 2c+1 low) |
| wrData | input | 8 | Byte to write |
| wrAck | output | 1 | One-cycle pulse in the write cycle |
| ramAddr | output | CH_W+1 | RAM byte address |
| ramWrData | output | 8 | RAM write data |
| ramWe | output | 1 | RAM write enable |
| ramRdData | input | 8 | RAM read data (asynchronous read) |
| dacHiStb | output | 1 | Loads DAC register bits 11..5 |
| dacLoStb | output | 1 | Loads DAC register bits 4..0 |
| dacValue | output | 12 | DAC register contents |
| muxAddr | output | CH_W | Demultiplexer channel address |
| muxInhibit | output | 1 | 1 keeps all demultiplexer channels closed |
| scanWrap | output | 1 | Pulse at each wrap of the channel scan |

## Verification
The hardest case to reach is a write that lands at each distinct point of a channel's slot: during either read, during settling, during the gate, or in the guard just after it. Each of these points needs a different recovery. The bench issues dozens of writes separated by idle gaps of 0 to 8 cycles against a short-timing configuration. The gaps do not divide the slot length, so the requests drift through every state, including back-to-back requests that arrive during the dead time. A monitor tracks the expected next channel and the RAM contents, and checks every gate opening, strobe and write against them.

// File: rtl/dacRefreshPkg.sv
package dacRefreshPkg;

  typedef enum logic [2:0] {
    ST_RDHI,
    ST_RDLO,
    ST_SETTLE,
    ST_GATE,
    ST_GUARD,
    ST_WRITE,
    ST_DEAD
  } seqState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic rdLo;      // address the low half of the channel
    logic hiStb;     // capture high half into DAC register
    logic loStb;     // capture low half, move mux address
    logic gateOpen;  // demultiplexer enabled
    logic advance;   // step to next channel
    logic ramWe;     // write cycle
  } seqStb_t;

endpackage

// File: rtl/dacRefreshCtrl.sv
module dacRefreshCtrl
  import dacRefreshPkg::*;
#(
  parameter int READ_CYC   = 14,
  parameter int SETTLE_CYC = 50,
  parameter int GATE_CYC   = 100,
  parameter int GUARD_CYC  = 4,
  parameter int DEAD_CYC   = 8
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    wrReq,
  output seqStb_t stb
);

  localparam int MAX_AB = (READ_CYC > SETTLE_CYC) ? READ_CYC : SETTLE_CYC;
  localparam int MAX_CD = (GATE_CYC > GUARD_CYC) ? GATE_CYC : GUARD_CYC;
  localparam int MAX_ABCD = (MAX_AB > MAX_CD) ? MAX_AB : MAX_CD;
  localparam int MAX_ALL = (MAX_ABCD > DEAD_CYC) ? MAX_ABCD : DEAD_CYC;
  localparam int CNT_W = $clog2(MAX_ALL + 1);

  localparam logic [CNT_W-1:0] RD_LAST  = CNT_W'(READ_CYC - 1);
  localparam logic [CNT_W-1:0] ST_LAST  = CNT_W'(SETTLE_CYC - 1);
  localparam logic [CNT_W-1:0] GT_LAST  = CNT_W'(GATE_CYC - 1);
  localparam logic [CNT_W-1:0] GD_LAST  = CNT_W'(GUARD_CYC - 1);
  localparam logic [CNT_W-1:0] DD_LAST  = CNT_W'(DEAD_CYC - 1);

  seqState_t curState, nextState;
  logic [CNT_W-1:0] phaseCnt;
  logic [CNT_W-1:0] lastCnt;
  logic phaseDone;

  always_comb begin
    unique case (curState)
      ST_RDHI, ST_RDLO: lastCnt = RD_LAST;
      ST_SETTLE:        lastCnt = ST_LAST;
      ST_GATE:          lastCnt = GT_LAST;
      ST_GUARD:         lastCnt = GD_LAST;
      ST_DEAD:          lastCnt = DD_LAST;
      default:          lastCnt = '0;
    endcase
  end

  assign phaseDone = (phaseCnt == lastCnt);

  always_comb begin
    nextState = curState;
    stb = '0;
    unique case (curState)
      ST_RDHI: begin
        if (wrReq) nextState = ST_WRITE;
        else if (phaseDone) begin
          stb.hiStb = 1'b1;
          nextState = ST_RDLO;
        end
      end
      ST_RDLO: begin
        stb.rdLo = 1'b1;
        if (wrReq) nextState = ST_WRITE;
        else if (phaseDone) begin
          stb.loStb = 1'b1;
          nextState = ST_SETTLE;
        end
      end
      ST_SETTLE: begin
        if (wrReq) nextState = ST_WRITE;
        else if (phaseDone) nextState = ST_GATE;
      end
      ST_GATE: begin
        stb.gateOpen = 1'b1;
        if (phaseDone) nextState = ST_GUARD;
      end
      ST_GUARD: begin
        if (wrReq) begin
          stb.advance = 1'b1;
          nextState = ST_WRITE;
        end else if (phaseDone) begin
          stb.advance = 1'b1;
          nextState = ST_RDHI;
        end
      end
      ST_WRITE: begin
        stb.ramWe = 1'b1;
        nextState = ST_DEAD;
      end
      ST_DEAD: begin
        if (phaseDone) nextState = ST_RDHI;
      end
      default: nextState = ST_RDHI;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curState <= ST_RDHI;
      phaseCnt <= '0;
    end else begin
      curState <= nextState;
      phaseCnt <= (nextState != curState) ? '0 : phaseCnt + 1'b1;
    end
  end

  AST_WE_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rstN)
    stb.ramWe |-> $past(wrReq)); // R8
  AST_WE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    stb.ramWe |=> !stb.ramWe); // R8
  AST_WE_NOT_AFTER_GATE: assert property (@(posedge clk) disable iff (!rstN)
    stb.ramWe |-> !$past(stb.gateOpen)); // R8
  AST_HI_NOT_IN_DEAD: assert property (@(posedge clk) disable iff (!rstN)
    stb.ramWe |=> !stb.hiStb && !stb.ramWe); // R9

endmodule

// File: rtl/dacRefreshDp.sv
module dacRefreshDp
  import dacRefreshPkg::*;
#(
  parameter int NUM_CH = 32,
  parameter int DAC_W  = 12,
  parameter int LO_W   = 5,
  localparam int CH_W  = $clog2(NUM_CH),
  localparam int HI_W  = DAC_W - LO_W
) (
  input  logic             clk,
  input  logic             rstN,
  input  seqStb_t          stb,
  input  logic [CH_W:0]    wrAddr,
  input  logic [7:0]       ramRdData,
  output logic [CH_W:0]    ramAddr,
  output logic [DAC_W-1:0] dacReg,
  output logic [CH_W-1:0]  muxAddr,
  output logic             scanWrap
);

  localparam logic [CH_W-1:0] LAST_CH = CH_W'(NUM_CH - 1);

  logic [CH_W-1:0] chan;
  logic unusedRd;

  assign unusedRd = ^ramRdData;
  assign ramAddr = stb.ramWe ? wrAddr : {chan, stb.rdLo};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      chan     <= '0;
      scanWrap <= 1'b0;
    end else begin
      scanWrap <= stb.advance && (chan == LAST_CH);
      if (stb.advance) chan <= (chan == LAST_CH) ? '0 : chan + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dacReg  <= '0;
      muxAddr <= '0;
    end else begin
      if (stb.hiStb) dacReg[DAC_W-1:LO_W] <= ramRdData[HI_W-1:0];
      if (stb.loStb) begin
        dacReg[LO_W-1:0] <= ramRdData[LO_W-1:0];
        muxAddr <= chan;
      end
    end
  end

  AST_MUX_MOVE_INHIBITED: assert property (@(posedge clk) disable iff (!rstN)
    (muxAddr != $past(muxAddr)) |-> (!stb.gateOpen && !$past(stb.gateOpen))); // R5
  AST_MUX_STABLE_OPEN: assert property (@(posedge clk) disable iff (!rstN)
    (stb.gateOpen && $past(stb.gateOpen)) |-> $stable(muxAddr)); // R5
  AST_DAC_STABLE_OPEN: assert property (@(posedge clk) disable iff (!rstN)
    (stb.gateOpen && $past(stb.gateOpen)) |-> $stable(dacReg)); // R5
  AST_WRAP_AT_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    scanWrap |-> (chan == '0) && ($past(chan) == LAST_CH)); // R6

endmodule

// File: rtl/dacRefreshSeq.sv
module dacRefreshSeq
  import dacRefreshPkg::*;
#(
  parameter int NUM_CH     = 32,
  parameter int READ_CYC   = 14,
  parameter int SETTLE_CYC = 50,
  parameter int GATE_CYC   = 100,
  parameter int GUARD_CYC  = 4,
  parameter int DEAD_CYC   = 8,
  localparam int CH_W      = $clog2(NUM_CH)
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            wrReq,
  input  logic [CH_W:0]   wrAddr,
  input  logic [7:0]      wrData,
  output logic            wrAck,
  output logic [CH_W:0]   ramAddr,
  output logic [7:0]      ramWrData,
  output logic            ramWe,
  input  logic [7:0]      ramRdData,
  output logic            dacHiStb,
  output logic            dacLoStb,
  output logic [11:0]     dacValue,
  output logic [CH_W-1:0] muxAddr,
  output logic            muxInhibit,
  output logic            scanWrap
);

  seqStb_t stb;

  dacRefreshCtrl #(
    .READ_CYC(READ_CYC), .SETTLE_CYC(SETTLE_CYC), .GATE_CYC(GATE_CYC),
    .GUARD_CYC(GUARD_CYC), .DEAD_CYC(DEAD_CYC)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .wrReq(wrReq), .stb(stb)
  );

  dacRefreshDp #(.NUM_CH(NUM_CH), .DAC_W(12), .LO_W(5)) uDp (
    .clk(clk), .rstN(rstN), .stb(stb), .wrAddr(wrAddr),
    .ramRdData(ramRdData), .ramAddr(ramAddr), .dacReg(dacValue),
    .muxAddr(muxAddr), .scanWrap(scanWrap)
  );

  assign ramWrData  = wrData;
  assign ramWe      = stb.ramWe;
  assign wrAck      = stb.ramWe;
  assign dacHiStb   = stb.hiStb;
  assign dacLoStb   = stb.loStb;
  assign muxInhibit = ~stb.gateOpen;

endmodule

// File: tb/sim_dacRefreshSeq.sv
module sim_dacRefreshSeq;
  localparam int N  = 8;
  localparam int RC = 2;
  localparam int SC = 3;
  localparam int GC = 4;
  localparam int GD = 2;
  localparam int DC = 3;
  localparam int CW = $clog2(N);
  localparam int PERIOD = 2 * RC + SC + GC + GD;

  logic clk = 0, rstN = 0, wrReq = 0;
  logic [CW:0] wrAddr = '0;
  logic [7:0] wrData = '0;
  logic wrAck, ramWe, dacHiStb, dacLoStb, muxInhibit, scanWrap;
  logic [CW:0] ramAddr;
  logic [7:0] ramWrData, ramRdData;
  logic [11:0] dacValue;
  logic [CW-1:0] muxAddr;
  logic [7:0] mem [2*N];

  int tests = 0, fails = 0, cyc = 0;
  int lastGated = N - 1, lastLo = -1, lastWe = -1, lastRise = -1;
  int openCnt = 0, wraps = 0, gates = 0;
  bit afterWe = 0, weSinceGate = 0, prevInh = 1, monOn = 0;
  logic [CW:0] expWrAddr;
  logic [7:0] expWrData;

  always #10 clk = ~clk;

  dacRefreshSeq #(.NUM_CH(N), .READ_CYC(RC), .SETTLE_CYC(SC), .GATE_CYC(GC),
    .GUARD_CYC(GD), .DEAD_CYC(DC)) u0 (
    .clk(clk), .rstN(rstN), .wrReq(wrReq), .wrAddr(wrAddr), .wrData(wrData),
    .wrAck(wrAck), .ramAddr(ramAddr), .ramWrData(ramWrData), .ramWe(ramWe),
    .ramRdData(ramRdData), .dacHiStb(dacHiStb), .dacLoStb(dacLoStb),
    .dacValue(dacValue), .muxAddr(muxAddr), .muxInhibit(muxInhibit),
    .scanWrap(scanWrap));

  assign ramRdData = mem[ramAddr];
  always @(posedge clk) if (ramWe) mem[ramAddr] <= ramWrData;

  function automatic logic [11:0] expVal(int c);
    return {mem[2*c][6:0], mem[2*c+1][4:0]};
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // monitor, sampled away from the active edge
  always @(negedge clk) begin
    cyc++;
    if (monOn) begin
      int nx;
      nx = (lastGated + 1) % N;
      if (wrAck !== ramWe) check(0, "R8 wrAck/ramWe", wrAck, ramWe);
      if (dacHiStb) begin
        check(ramAddr == 2 * nx, "R2 hi address", ramAddr, 2 * nx);
        if (afterWe) check(cyc - lastWe == DC + RC, "R9 dead time", cyc - lastWe, DC + RC);
        afterWe = 0;
      end
      if (dacLoStb) begin
        check(ramAddr == 2 * nx + 1, "R2 lo address", ramAddr, 2 * nx + 1);
        lastLo = cyc;
      end
      if (ramWe) begin
        check(muxInhibit == 1'b1, "R8 write with gate closed", muxInhibit, 1);
        check(ramAddr == expWrAddr && ramWrData == expWrData, "R8 write bus",
              {ramAddr, ramWrData}, {expWrAddr, expWrData});
        if (lastWe >= 0) check(cyc - lastWe >= DC + 1, "R9 request ignored in dead time",
                               cyc - lastWe, DC + 1);
        afterWe = 1; lastWe = cyc; weSinceGate = 1;
      end
      if (!muxInhibit && prevInh) begin
        gates++;
        check(muxAddr == nx, "R6 R10 channel order", muxAddr, nx);
        check(dacValue == expVal(muxAddr), "R3 R11 dac value", dacValue, expVal(muxAddr));
        check(cyc - lastLo == SC + 1, "R4 settle", cyc - lastLo, SC + 1);
        if (lastRise >= 0 && !weSinceGate)
          check(cyc - lastRise == PERIOD, "R7 slot period", cyc - lastRise, PERIOD);
        lastRise = cyc; weSinceGate = 0; lastGated = muxAddr; openCnt = 1;
      end else if (!muxInhibit) begin
        openCnt++;
      end
      if (muxInhibit && !prevInh) check(openCnt == GC, "R5 gate length", openCnt, GC);
      if (scanWrap) begin
        wraps++;
        check(lastGated == N - 1, "R6 wrap after last channel", lastGated, N - 1);
      end
      prevInh = muxInhibit;
    end
  end

  task automatic doWrite(int a, int d);
    int n = 0;
    expWrAddr = a[CW:0]; expWrData = d[7:0];
    wrAddr = a[CW:0]; wrData = d[7:0]; wrReq = 1;
    do begin
      @(negedge clk);
      n++;
    end while (!wrAck && n < 1000);
    wrReq = 0;
    check(n <= GC + 2, "R8 write latency", n, GC + 2);
  endtask

  initial begin
    for (int i = 0; i < 2 * N; i++) mem[i] = 8'((i * 37 + 11) % 256);
    repeat (3) @(negedge clk);
    check(muxInhibit == 1 && !dacHiStb && !dacLoStb && !ramWe && !wrAck && !scanWrap,
          "R1 reset outputs", {muxInhibit, dacHiStb, dacLoStb, ramWe, wrAck, scanWrap}, 6'b100000);
    check(dacValue == 0, "R1 reset dac", dacValue, 0);
    rstN = 1; monOn = 1;
    repeat (2 * N * PERIOD + 10) @(negedge clk);
    // writes drifting through every slot phase
    for (int p = 0; p < 3; p++)
      for (int i = 0; i < 2 * N; i++) begin
        doWrite((i * 5 + p) % (2 * N), (i * 53 + p * 91 + 17) % 256);
        repeat ((i + p) % 9) @(negedge clk);
      end
    repeat (2 * N * PERIOD + 10) @(negedge clk);
    check(wraps >= 4, "R6 wrap count", wraps, 4);
    check(gates >= 4 * N, "R7 gate count", gates, 4 * N);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    fails++; tests++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule